// File: doc/BRIEF.md
# Hamming (7,4) Encoder and Single-Error Corrector

This block protects 4-bit data words with three even-parity checks. Each check covers three of the four data bits. The encode path takes a data word with a valid strobe and returns the 7-bit codeword one clock later. The four data bits come first, most significant first, followed by the three check bits.

The decode path takes a received 7-bit codeword with its own valid strobe. It recomputes the three checks and combines them into a 3-bit syndrome. A single-bit error anywhere in the word is repaired. The corrected data word and two flags come out one clock after the strobe: one flag reports any detected error, the other reports that a data bit was repaired. The two paths share only the clock and the reset. Both paths can be used in the same cycle.

Top module: `ham74_codec`

## Requirements
- R1: With data bits d[3..0] = a,b,c,e (a most significant), the codeword is {a,b,c,e,q2,q1,q0}, where q2 = a^b^c, q1 = b^c^e and q0 = a^c^e. Data 1011 gives check bits 001, 0110 gives 001, 1111 gives 111 and 0000 gives 000.
- R2: `enc_valid_o` is high in the cycle after a cycle in which `enc_valid_i` was high, and low otherwise.
- R3: `enc_code_o` keeps its value in every cycle that follows a cycle without an encode strobe, whatever `enc_data_i` does.
- R4: A received word whose three checks are all even yields its own data bits on `dec_data_o`, with `dec_err_o` and `dec_fix_o` low.
- R5: A word with exactly one flipped data bit (codeword bits 6..3) yields the original data, with `dec_err_o` and `dec_fix_o` both high. The syndrome {q2 check, q1 check, q0 check} is 101 for bit 6, 110 for bit 5, 111 for bit 4 and 011 for bit 3.
- R6: A word with exactly one flipped check bit (codeword bits 2..0) yields its data bits unchanged, with `dec_err_o` high and `dec_fix_o` low.
- R7: `dec_valid_o` is high in the cycle after a cycle in which `dec_valid_i` was high, and low otherwise. All decode outputs hold when no decode strobe occurred.
- R8: While `rst` is high at a clock edge, every output is cleared to zero on that edge, even if a strobe is present.
- R9: An encode strobe leaves every decode output unchanged, and a decode strobe leaves every encode output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Encode strobe |
| enc_data_i | input | 4 | Data word to encode |
| enc_valid_o | output | 1 | Codeword valid, one cycle after the strobe |
| enc_code_o | output | 7 | Codeword: data bits, then three check bits |
| dec_valid_i | input | 1 | Decode strobe |
| dec_code_i | input | 7 | Received codeword |
| dec_valid_o | output | 1 | Decode result valid, one cycle after the strobe |
| dec_data_o | output | 4 | Corrected data word |
| dec_err_o | output | 1 | Nonzero syndrome was seen |
| dec_fix_o | output | 1 | A data bit was repaired |

## Verification
Some properties are checked by assertions on every clock:
- strobe-to-valid latency on both paths;
- hold of the codeword between strobes;
- even parity of every emitted codeword;
- the repair flag never appearing without the error flag;
- clean words and single check-bit errors passing the data through untouched.

The bench scenarios cover what needs known expected values:
- the four sample codewords;
- all sixteen data words encoded;
- every one of the seven single-bit errors injected into each of the sixteen codewords, with the original data recovered;
- reset clearing the outputs while strobes are held high;
- the two paths leaving each other's outputs alone.

// File: rtl/ham74_pkg.sv
package ham74_pkg;

    localparam int DATA_W = 4;
    localparam int PAR_W  = 3;
    localparam int CW_W   = DATA_W + PAR_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [PAR_W-1:0]  par_t;

    // Codeword: data in the upper bits, check bits in the lower bits.
    typedef struct packed {
        data_t data;
        par_t  par;
    } cw_t;

    // Data bits covered by each check; index k is syndrome / check bit k.
    // Check 2 is the first check, check 0 the last.
    localparam logic [PAR_W-1:0][DATA_W-1:0] COVER = {
        4'b1110,   // check 2: a b c
        4'b0111,   // check 1: b c e
        4'b1011    // check 0: a c e
    };

    function automatic par_t calc_par(data_t d);
        par_t p;
        for (int k = 0; k < PAR_W; k++) p[k] = ^(d & COVER[k]);
        return p;
    endfunction

    // Syndrome pattern produced by a flip of data bit i.
    function automatic par_t data_column(int i);
        par_t c;
        for (int k = 0; k < PAR_W; k++) c[k] = COVER[k][i];
        return c;
    endfunction

endpackage

// File: rtl/ham74_encoder.sv
module ham74_encoder
    import ham74_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid_i,
    input  data_t data_i,
    output logic  valid_o,
    output cw_t   code_o
);

    cw_t code_d;

    always_comb begin
        code_d.data = data_i;
        code_d.par  = calc_par(data_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) code_o <= code_d;
        end
    end

    // R2: output valid follows the strobe by one cycle
    p_enc_lat_r2: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    p_enc_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
    // R3: codeword holds without a strobe
    p_enc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(code_o));
    // R1: every emitted codeword satisfies all three even checks
    p_enc_even_r1: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (calc_par(code_o.data) ^ code_o.par) == '0);

endmodule

// File: rtl/ham74_syndrome.sv
module ham74_syndrome
    import ham74_pkg::*;
(
    input  cw_t  code_i,
    output par_t syn_o
);

    for (genvar k = 0; k < PAR_W; k++) begin : g_check
        assign syn_o[k] = ^(code_i.data & COVER[k]) ^ code_i.par[k];
    end

endmodule

// File: rtl/ham74_decoder.sv
module ham74_decoder
    import ham74_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid_i,
    input  cw_t   code_i,
    output logic  valid_o,
    output data_t data_o,
    output logic  err_o,
    output logic  fix_o
);

    par_t  syn;
    data_t flip;
    data_t data_d;

    ham74_syndrome u_syn (
        .code_i (code_i),
        .syn_o  (syn)
    );

    // One comparator per data bit against that bit's syndrome column.
    for (genvar i = 0; i < DATA_W; i++) begin : g_flip
        assign flip[i] = (syn == data_column(i));
    end

    assign data_d = code_i.data ^ flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            err_o   <= 1'b0;
            fix_o   <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                data_o <= data_d;
                err_o  <= |syn;
                fix_o  <= |flip;
            end
        end
    end

    // R7: result valid follows the strobe by one cycle, outputs hold otherwise
    p_dec_lat_r7: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    p_dec_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!valid_o && $stable(data_o) && $stable(err_o) && $stable(fix_o)));
    // R5: a repair is always also a detection
    p_fix_needs_err_r5: assert property (@(posedge clk) disable iff (rst)
        fix_o |-> err_o);
    // R4: clean words pass through unflagged
    p_clean_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && syn == '0) |=> (!err_o && !fix_o && data_o == $past(code_i.data)));
    // R6: a lone check-bit error leaves the data alone
    p_par_err_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_i && $countones(syn) == 1) |=> (err_o && !fix_o && data_o == $past(code_i.data)));

endmodule

// File: rtl/ham74_codec.sv
module ham74_codec
    import ham74_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_valid_i,
    input  logic [3:0] enc_data_i,
    output logic       enc_valid_o,
    output logic [6:0] enc_code_o,
    input  logic       dec_valid_i,
    input  logic [6:0] dec_code_i,
    output logic       dec_valid_o,
    output logic [3:0] dec_data_o,
    output logic       dec_err_o,
    output logic       dec_fix_o
);

    cw_t enc_cw;
    cw_t dec_cw;

    assign dec_cw     = dec_code_i;
    assign enc_code_o = enc_cw;

    ham74_encoder u_enc (
        .clk     (clk),
        .rst     (rst),
        .valid_i (enc_valid_i),
        .data_i  (enc_data_i),
        .valid_o (enc_valid_o),
        .code_o  (enc_cw)
    );

    ham74_decoder u_dec (
        .clk     (clk),
        .rst     (rst),
        .valid_i (dec_valid_i),
        .code_i  (dec_cw),
        .valid_o (dec_valid_o),
        .data_o  (dec_data_o),
        .err_o   (dec_err_o),
        .fix_o   (dec_fix_o)
    );

    // R8: one cycle after reset every output is cleared
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!enc_valid_o && !dec_valid_o && enc_code_o == '0 &&
                 dec_data_o == '0 && !dec_err_o && !dec_fix_o));

endmodule

// File: tb/tb_ham74_codec.sv
module tb_ham74_codec;

    localparam int PERIOD = 10;
    localparam int WD_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst;
    logic       enc_valid_i;
    logic [3:0] enc_data_i;
    logic       enc_valid_o;
    logic [6:0] enc_code_o;
    logic       dec_valid_i;
    logic [6:0] dec_code_i;
    logic       dec_valid_o;
    logic [3:0] dec_data_o;
    logic       dec_err_o;
    logic       dec_fix_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    ham74_codec dut (
        .clk         (clk),
        .rst         (rst),
        .enc_valid_i (enc_valid_i),
        .enc_data_i  (enc_data_i),
        .enc_valid_o (enc_valid_o),
        .enc_code_o  (enc_code_o),
        .dec_valid_i (dec_valid_i),
        .dec_code_i  (dec_code_i),
        .dec_valid_o (dec_valid_o),
        .dec_data_o  (dec_data_o),
        .dec_err_o   (dec_err_o),
        .dec_fix_o   (dec_fix_o)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_code(input logic [3:0] d);
        logic q2, q1, q0;
        q2 = d[3] ^ d[2] ^ d[1];
        q1 = d[2] ^ d[1] ^ d[0];
        q0 = d[3] ^ d[1] ^ d[0];
        return {d, q2, q1, q0};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    task automatic encode(input logic [3:0] d);
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        @(negedge clk);
        enc_valid_i = 1'b0;
    endtask

    task automatic decode(input logic [6:0] c);
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_code_i  = c;
        @(negedge clk);
        dec_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        enc_valid_i = 1'b1; enc_data_i = 4'hF;
        dec_valid_i = 1'b1; dec_code_i = 7'h55;
        repeat (3) @(negedge clk);
        check(enc_valid_o == 0 && dec_valid_o == 0, "R8 valids", {6'd0, enc_valid_o, dec_valid_o}, 8'h00);
        check(enc_code_o == 0, "R8 code", {1'b0, enc_code_o}, 8'h00);
        check(dec_data_o == 0 && !dec_err_o && !dec_fix_o, "R8 decode",
              {2'b0, dec_data_o, dec_err_o, dec_fix_o}, 8'h00);
        enc_valid_i = 1'b0; dec_valid_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_known();
        logic [3:0] dv [4] = '{4'b1011, 4'b0110, 4'b1111, 4'b0000};
        logic [2:0] pv [4] = '{3'b001, 3'b001, 3'b111, 3'b000};
        for (int i = 0; i < 4; i++) begin
            encode(dv[i]);
            check(enc_code_o == {dv[i], pv[i]}, "R1 sample", {1'b0, enc_code_o}, {1'b0, dv[i], pv[i]});
        end
    endtask

    task automatic t_all_encode();
        for (int d = 0; d < 16; d++) begin
            encode(d[3:0]);
            check(enc_valid_o == 1'b1, "R2 valid high", {7'd0, enc_valid_o}, 8'h01);
            check(enc_code_o == ref_code(d[3:0]), "R1 encode", {1'b0, enc_code_o}, {1'b0, ref_code(d[3:0])});
        end
        @(negedge clk);
        check(enc_valid_o == 1'b0, "R2 valid low", {7'd0, enc_valid_o}, 8'h00);
    endtask

    task automatic t_hold();
        encode(4'b1011);
        for (int i = 0; i < 3; i++) begin
            enc_data_i = 4'(i + 4);
            @(negedge clk);
            check(enc_code_o == 7'b1011001, "R3 hold", {1'b0, enc_code_o}, 8'h59);
        end
    endtask

    task automatic t_clean();
        for (int d = 0; d < 16; d++) begin
            decode(ref_code(d[3:0]));
            check(dec_valid_o == 1'b1, "R7 valid", {7'd0, dec_valid_o}, 8'h01);
            check(dec_data_o == d[3:0] && !dec_err_o && !dec_fix_o, "R4 clean",
                  {2'b0, dec_data_o, dec_err_o, dec_fix_o}, {2'b0, d[3:0], 2'b00});
        end
        @(negedge clk);
        check(dec_valid_o == 1'b0, "R7 valid low", {7'd0, dec_valid_o}, 8'h00);
    endtask

    task automatic t_single_errors();
        for (int d = 0; d < 16; d++) begin
            for (int b = 0; b < 7; b++) begin
                logic [6:0] bad;
                logic       exp_fix;
                bad = ref_code(d[3:0]) ^ (7'd1 << b);
                exp_fix = (b >= 3);
                decode(bad);
                check(dec_data_o == d[3:0] && dec_err_o && dec_fix_o == exp_fix,
                      exp_fix ? "R5 data-bit error" : "R6 check-bit error",
                      {2'b0, dec_data_o, dec_err_o, dec_fix_o}, {2'b0, d[3:0], 1'b1, exp_fix});
            end
        end
    endtask

    task automatic t_independent();
        decode(ref_code(4'b0110) ^ 7'b0100000);
        encode(4'b1001);
        check(dec_data_o == 4'b0110 && dec_err_o && dec_fix_o && !dec_valid_o, "R9 decode untouched",
              {1'b0, dec_valid_o, dec_data_o, dec_err_o, dec_fix_o}, {2'b0, 4'b0110, 2'b11});
        decode(7'b0000001);
        check(enc_code_o == ref_code(4'b1001) && !enc_valid_o, "R9 encode untouched",
              {enc_valid_o, enc_code_o}, {1'b0, ref_code(4'b1001)});
        check(dec_data_o == 4'b0000 && dec_err_o && !dec_fix_o, "R7 hold prior R6",
              {2'b0, dec_data_o, dec_err_o, dec_fix_o}, 8'h02);
        @(negedge clk);
        check(dec_data_o == 4'b0000 && dec_err_o && !dec_fix_o && !dec_valid_o, "R7 hold",
              {1'b0, dec_valid_o, dec_data_o, dec_err_o, dec_fix_o}, 8'h02);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_known();
        t_all_encode();
        t_hold();
        t_clean();
        t_single_errors();
        t_independent();
        summary();
        $finish;
    end

endmodule